// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block passes 16-bit words in both directions between a host processor and an audio coprocessor. The host drops a command word into one latch and the coprocessor drops its answer into another. Each latch has its own ready flag, which the writer sets and the reader clears. Both processors can see both flags. The host sees them in a small status field. The coprocessor sees them in a status byte and on two of its flag input pins.

A host control register also acts as the coprocessor reset. If the two low bits of the control value are zero, the coprocessor is held in reset and both ready flags are wiped. Any other value lets the coprocessor run.

The host interrupt carries a two-bit reason vector:
- The data-ready reason fires when a reply is waiting and control bit 1 is set.
- The buffer-empty reason fires when the command latch has been consumed, but only with both low control bits set.

A new command also raises a one-cycle command interrupt toward the coprocessor.

Top module: `cmd_mailbox`

## Requirements
- R1: After a synchronous reset, both flags and both latches are zero, the control register is zero, `cop_reset` is high, both interrupts are low, and `cop_status` reads 8'h40.
- R2: A host command write stores `host_cmd_data`. On the next clock it sets the to-coprocessor flag, shows the word on `cop_cmd_data`, and pulses `cop_cmd_irq` high for exactly one cycle.
- R3: A coprocessor command read clears the to-coprocessor flag. If a host command write lands in the same cycle, the flag ends set.
- R4: A coprocessor reply write stores `cop_reply_data` and sets the to-host flag. A host reply read clears that flag. If both land in the same cycle, the flag ends set.
- R5: `host_status` bit 1 is the to-coprocessor flag and bit 0 is the to-host flag.
- R6: A control write whose bits 1:0 are 00 raises `cop_reset` and clears both flags on the next clock. This overrides any set in the same cycle. A control write with any other low bits releases `cop_reset`.
- R7: While `cop_reset` is high, `cop_cmd_rd` and `cop_reply_wr` have no effect on either flag or on the reply latch.
- R8: `host_irq_reason` bit 0 (buffer empty) is 1 when control bits 1:0 equal 3 and the to-coprocessor flag is clear. Bit 1 (data ready) is 1 when control bit 1 is set and the to-host flag is set. `host_irq` is the OR of the two bits.
- R9: In `cop_status`, bit 7 is the to-coprocessor flag and bit 6 is the inverse of the to-host flag. In `cop_flags`, bit 3 is the to-coprocessor flag and bit 7 is the to-host flag. All other bits of both outputs are 0.
- R10: A latch keeps its word until its writer stores a new one. Reads and control writes do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cmd_wr | input | 1 | Host writes a command word |
| host_cmd_data | input | 16 | Command word from host |
| host_reply_rd | input | 1 | Host reads the reply word |
| host_reply_data | output | 16 | Latched reply word |
| host_ctrl_wr | input | 1 | Host writes the control register |
| host_ctrl_wdata | input | 16 | Control value |
| host_status | output | 2 | Flags as seen by the host |
| host_irq | output | 1 | Host interrupt |
| host_irq_reason | output | 2 | Interrupt reasons: bit 0 buffer empty, bit 1 data ready |
| cop_cmd_rd | input | 1 | Coprocessor reads the command word |
| cop_cmd_data | output | 16 | Latched command word |
| cop_reply_wr | input | 1 | Coprocessor writes a reply word |
| cop_reply_data | input | 16 | Reply word from coprocessor |
| cop_status | output | 8 | Coprocessor status byte |
| cop_flags | output | 8 | Coprocessor flag input pins |
| cop_cmd_irq | output | 1 | One-cycle command interrupt |
| cop_reset | output | 1 | Holds the coprocessor in reset |

## Verification
Every flag, latch and control effect is registered once. Each one is due on the first clock edge after the strobe. The status bytes, flag pins and interrupt reasons are decoded straight from those registers, so they change on that same edge. The command interrupt is also high only for the cycle that follows the write.

The bench changes inputs 1 ns after a rising edge and compares every output after the next rising edge. It uses a model that applies the requirement rules to the state from before that edge. The sweep covers:
- all four starting flag pairs,
- all four control low-bit values,
- all 32 combinations of the five strobes.

// File: rtl/mbx_pkg.sv
// Shared constants for the command mailbox.
// Holds the reason-vector bit positions and the status/flag bit positions
// that the two processors decode. Assumes an 8-bit coprocessor status byte.
package mbx_pkg;
    localparam int REASON_W     = 2;
    localparam int RSN_EMPTY    = 0;   // buffer-empty reason bit
    localparam int RSN_READY    = 1;   // data-ready reason bit
    localparam int COP_W        = 8;
    localparam int STAT_CMD_BIT = 7;   // to-coprocessor flag in status byte
    localparam int STAT_RPL_N   = 6;   // inverted to-host flag in status byte
    localparam int PIN_CMD_BIT  = 3;   // to-coprocessor flag on flag pins
    localparam int PIN_RPL_BIT  = 7;   // to-host flag on flag pins

    typedef struct packed {
        logic to_cop;
        logic to_host;
    } mbx_flags_t;
endpackage

// File: rtl/mbx_channel.sv
// One direction of the mailbox: a data latch plus its ready flag.
// The writer sets the flag, the reader clears it, and a clear request wipes it.
// A clear request beats a write, and a write beats a read.
// Assumes strobes are single-cycle and already gated by the caller.
module mbx_channel #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic [DATA_W-1:0] data,
    output logic              ready
);
    // Capture the word on a write; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  data <= '0;
        else if (wr) data <= wdata;
    end

    // Ready flag: clear request first, then set, then consume.
    always_ff @(posedge clk) begin
        if (!rst_n)    ready <= 1'b0;
        else if (clr)  ready <= 1'b0;
        else if (wr)   ready <= 1'b1;
        else if (rd)   ready <= 1'b0;
    end

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> ready);
    assert_clear_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !ready);
    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(data));
endmodule

// File: rtl/mbx_ctrl.sv
// Host control register and the coprocessor reset it drives.
// When the low two bits of a written value are both zero, this module asks for
// both flags to be cleared in the same cycle. Reset is held while bits 1:0 are 00.
module mbx_ctrl #(
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              clr_flags,
    output logic              cop_reset
);
    // Store the control value written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)  ctrl_q <= '0;
        else if (wr) ctrl_q <= wdata;
    end

    // Flag wipe request accompanies a write that parks the coprocessor.
    always_comb clr_flags = wr && (wdata[1:0] == 2'b00);

    // Coprocessor stays in reset while both low control bits are zero.
    always_comb cop_reset = (ctrl_q[1:0] == 2'b00);

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[1:0] != 2'b00) |=> !cop_reset);
endmodule

// File: rtl/mbx_irq.sv
// Host interrupt reason decode.
// Buffer empty needs both low control bits set and the command latch consumed.
// Data ready needs control bit 1 and a pending reply. Purely combinational.
module mbx_irq
    import mbx_pkg::*;
(
    input  logic [1:0]          ctrl_lo,
    input  mbx_flags_t          flags,
    output logic [REASON_W-1:0] reason,
    output logic                irq
);
    // Build each reason bit from the control bits and the flags.
    always_comb begin
        reason            = '0;
        reason[RSN_EMPTY] = (ctrl_lo == 2'b11) && !flags.to_cop;
        reason[RSN_READY] = ctrl_lo[1] && flags.to_host;
    end

    // Any active reason raises the host interrupt.
    always_comb irq = |reason;
endmodule

// File: rtl/cmd_mailbox.sv
// Top of the host/coprocessor command mailbox.
// Joins the two channels, the control register and the interrupt decode. It
// gates the coprocessor strobes while the coprocessor is in reset and drives the
// coprocessor status byte and flag pins. Assumes one clock domain, with both
// processors' strobes already registered into it.
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CTRL_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_cmd_wr,
    input  logic [DATA_W-1:0]   host_cmd_data,
    input  logic                host_reply_rd,
    output logic [DATA_W-1:0]   host_reply_data,
    input  logic                host_ctrl_wr,
    input  logic [CTRL_W-1:0]   host_ctrl_wdata,
    output logic [1:0]          host_status,
    output logic                host_irq,
    output logic [REASON_W-1:0] host_irq_reason,
    input  logic                cop_cmd_rd,
    output logic [DATA_W-1:0]   cop_cmd_data,
    input  logic                cop_reply_wr,
    input  logic [DATA_W-1:0]   cop_reply_data,
    output logic [COP_W-1:0]    cop_status,
    output logic [COP_W-1:0]    cop_flags,
    output logic                cop_cmd_irq,
    output logic                cop_reset
);
    localparam int NCHAN = 2;

    logic [CTRL_W-1:0] ctrl_q;
    logic              clr_flags;
    logic              cop_rd_g;
    logic              cop_wr_g;
    mbx_flags_t        flags;
    logic [NCHAN-1:0]  flag_vec;

    mbx_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (host_ctrl_wr),
        .wdata     (host_ctrl_wdata),
        .ctrl_q    (ctrl_q),
        .clr_flags (clr_flags),
        .cop_reset (cop_reset)
    );

    // Drop coprocessor strobes while the coprocessor is parked.
    always_comb begin
        cop_rd_g = cop_cmd_rd   && !cop_reset;
        cop_wr_g = cop_reply_wr && !cop_reset;
    end

    mbx_channel #(.DATA_W(DATA_W)) u_to_cop (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_flags),
        .wr    (host_cmd_wr),
        .wdata (host_cmd_data),
        .rd    (cop_rd_g),
        .data  (cop_cmd_data),
        .ready (flags.to_cop)
    );

    mbx_channel #(.DATA_W(DATA_W)) u_to_host (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_flags),
        .wr    (cop_wr_g),
        .wdata (cop_reply_data),
        .rd    (host_reply_rd),
        .data  (host_reply_data),
        .ready (flags.to_host)
    );

    mbx_irq u_irq (
        .ctrl_lo (ctrl_q[1:0]),
        .flags   (flags),
        .reason  (host_irq_reason),
        .irq     (host_irq)
    );

    // One-cycle command interrupt after an accepted host command write.
    always_ff @(posedge clk) begin
        if (!rst_n) cop_cmd_irq <= 1'b0;
        else        cop_cmd_irq <= host_cmd_wr && !clr_flags;
    end

    // Host view of both flags: bit 1 command pending, bit 0 reply pending.
    always_comb flag_vec = {flags.to_cop, flags.to_host};
    always_comb host_status = flag_vec;

    // Place flags into the coprocessor status byte and onto its flag pins.
    for (genvar b = 0; b < COP_W; b++) begin : g_cop_bits
        if (b == STAT_CMD_BIT) begin : g_s_cmd
            assign cop_status[b] = flags.to_cop;
        end else if (b == STAT_RPL_N) begin : g_s_rpl
            assign cop_status[b] = !flags.to_host;
        end else begin : g_s_zero
            assign cop_status[b] = 1'b0;
        end
        if (b == PIN_CMD_BIT) begin : g_p_cmd
            assign cop_flags[b] = flags.to_cop;
        end else if (b == PIN_RPL_BIT) begin : g_p_rpl
            assign cop_flags[b] = flags.to_host;
        end else begin : g_p_zero
            assign cop_flags[b] = 1'b0;
        end
    end

    assert_cmd_irq_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cop_cmd_irq |-> flags.to_cop);
    assert_reply_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_reset && !flags.to_host) |=> !flags.to_host);
    assert_parked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cop_reset |-> !host_irq);
    assert_cmd_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_cmd_rd && !cop_reset && !host_cmd_wr) |=> !flags.to_cop);
endmodule

// File: tb/cmd_mailbox_test.sv
// Self-checking bench: near-exhaustive strobe sweep against a rule model.
module cmd_mailbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cmd_wr = 1'b0;
    logic [15:0] host_cmd_data = '0;
    logic        host_reply_rd = 1'b0;
    logic [15:0] host_reply_data;
    logic        host_ctrl_wr = 1'b0;
    logic [15:0] host_ctrl_wdata = '0;
    logic [1:0]  host_status;
    logic        host_irq;
    logic [1:0]  host_irq_reason;
    logic        cop_cmd_rd = 1'b0;
    logic [15:0] cop_cmd_data;
    logic        cop_reply_wr = 1'b0;
    logic [15:0] cop_reply_data = '0;
    logic [7:0]  cop_status;
    logic [7:0]  cop_flags;
    logic        cop_cmd_irq;
    logic        cop_reset;

    int errors = 0;
    int checks = 0;

    // model state
    logic        m_cop = 0, m_host = 0, m_irq = 0;
    logic [15:0] m_ctrl = '0, m_cmd = '0, m_rpl = '0;

    always #4 clk = ~clk;   // 125 MHz

    cmd_mailbox uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(input string tag);
        logic [1:0] er;
        er[0] = (m_ctrl[1:0] == 2'b11) && !m_cop;
        er[1] = m_ctrl[1] && m_host;
        chk({tag, " R5 host_status"}, 32'(host_status), 32'({m_cop, m_host}));
        chk({tag, " R9 cop_status"}, 32'(cop_status), 32'({m_cop, ~m_host, 6'b0}));
        chk({tag, " R9 cop_flags"}, 32'(cop_flags), 32'({m_host, 3'b0, m_cop, 3'b0}));
        chk({tag, " R8 reason"}, 32'(host_irq_reason), 32'(er));
        chk({tag, " R8 host_irq"}, 32'(host_irq), 32'(|er));
        chk({tag, " R6 cop_reset"}, 32'(cop_reset), 32'(m_ctrl[1:0] == 2'b00));
        chk({tag, " R2 cop_cmd_data"}, 32'(cop_cmd_data), 32'(m_cmd));
        chk({tag, " R4 host_reply_data"}, 32'(host_reply_data), 32'(m_rpl));
        chk({tag, " R2 cop_cmd_irq"}, 32'(cop_cmd_irq), 32'(m_irq));
    endtask

    // Drive one cycle of strobes, advance the model by the requirement rules, check.
    task automatic op(input string tag, input logic hw, input logic [15:0] hd,
                      input logic crd, input logic cw, input logic [15:0] cd,
                      input logic hrd, input logic cwr, input logic [15:0] cv);
        logic clr, parked;
        host_cmd_wr = hw; host_cmd_data = hd; cop_cmd_rd = crd;
        cop_reply_wr = cw; cop_reply_data = cd; host_reply_rd = hrd;
        host_ctrl_wr = cwr; host_ctrl_wdata = cv;
        clr    = cwr && (cv[1:0] == 2'b00);
        parked = (m_ctrl[1:0] == 2'b00);
        tick();
        if (clr) m_cop = 0; else if (hw) m_cop = 1; else if (crd && !parked) m_cop = 0;
        if (clr) m_host = 0; else if (cw && !parked) m_host = 1; else if (hrd) m_host = 0;
        if (hw) m_cmd = hd;
        if (cw && !parked) m_rpl = cd;
        if (cwr) m_ctrl = cv;
        m_irq = hw && !clr;
        host_cmd_wr = 0; cop_cmd_rd = 0; cop_reply_wr = 0;
        host_reply_rd = 0; host_ctrl_wr = 0;
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();
        check_all("R1 reset");
        chk("R1 cop_status after reset", 32'(cop_status), 32'h40);

        // R7: parked coprocessor strobes ignored
        op("R7 parked", 0, 16'h0, 1, 1, 16'hBEEF, 0, 0, 16'h0);
        // R2: command write, then R10 hold across idle cycle
        op("R2 cmd", 1, 16'h1234, 0, 0, 16'h0, 0, 1, 16'h0003);
        op("R10 idle", 0, 16'h0, 0, 0, 16'h0, 0, 0, 16'h0);
        // R4: reply set and same-cycle read, R3: read and write together
        op("R4 reply", 0, 16'h0, 0, 1, 16'h5A5A, 1, 0, 16'h0);
        op("R3 rdwr", 1, 16'h4321, 1, 0, 16'h0, 0, 0, 16'h0);
        op("R3 rd", 0, 16'h0, 1, 0, 16'h0, 0, 0, 16'h0);
        // R6: park overrides same-cycle sets
        op("R6 park", 1, 16'h7777, 0, 1, 16'h1111, 0, 1, 16'hFF00);

        // near-exhaustive sweep: start flags x control bits x strobe masks
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                for (int m = 0; m < 32; m++) begin
                    n++;
                    op("R10 setup", 0, 16'h0, 0, 0, 16'h0, 0, 1, 16'h0003);
                    op("R5 flags", s[1], 16'hA000 + 16'(n), !s[1], s[0],
                       16'h3000 + 16'(n * 7), !s[0], 0, 16'h0);
                    op("R8 ctrl", 0, 16'h0, 0, 0, 16'h0, 0, 1, 16'h0100 | 16'(c));
                    op("R7 sweep", m[0], 16'hC000 ^ 16'(n * 13), m[1], m[2],
                       16'h0F00 + 16'(n), m[3], m[4], 16'h0200 | 16'((m + c) % 4));
                    op("R2 after", 0, 16'h0, 0, 0, 16'h0, 0, 0, 16'h0);
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule